// File: doc/BRIEF.md
# Two-Channel DMA Cycle Arbiter

This block decides which of two DMA channels owns the shared transfer bus for each cycle. The host starts a channel with a strobe and a cycle count. Each channel also has a level-sensitive request from its peripheral, an external terminate input, a per-channel enable for that terminate input, and a 1-bit priority. The block grants one bus cycle at a time. A plain cycle-done handshake (`cyc_done_i`, `cyc_err_i`) stands in for the actual memory or I/O cycle. When the two channels have the same priority and both are requesting, ownership alternates cycle by cycle.

A channel's transfer ends in one of three ways: its programmed count runs out, an enabled external terminate arrives, or a cycle reports an error. When a transfer ends, the channel's interrupt line goes high and stays high until the host clears it. An error ending also sets a sticky error flag, so the host can tell the two kinds of ending apart.

Top module: `dpa_arbiter`

## Requirements
- R1: A synchronous active-high `rst` leaves both channels inactive, with no cycle requested and with all interrupt and error flags low from the first edge after it.
- R2: A start strobe with a nonzero `len_i` makes an inactive channel active and loads `len_i` cycles. A start with `len_i` = 0, or a start to a channel that is already active, has no effect.
- R3: A new cycle is raised (`cyc_req_o` rises, `cyc_ch_o` = 0 for channel 0 or 1 for channel 1) only for an active channel whose request was high at the granting edge. `cyc_req_o` and `cyc_ch_o` hold until `cyc_done_i`, and after each done there is at least one cycle with `cyc_req_o` low.
- R4: The request input acts as a level. An active channel whose request is low gets no cycle.
- R5: When both channels are eligible and their `prio_i` bits differ, the channel with its bit set to 1 wins every cycle.
- R6: When both channels are eligible with equal priority, grants alternate strictly, and channel 0 goes first after reset.
- R7: The alternation turn moves only on a grant, to the other channel. A channel that is not requesting does not use up its turn.
- R8: When a channel's last programmed cycle completes, it goes inactive and its interrupt rises at the same edge.
- R9: A rising edge on `term_i` of an active channel whose `term_en_i` bit is 1 ends that transfer at once and raises the channel's interrupt. A terminate level held high afterwards does not end a later restarted transfer.
- R10: A terminate edge on a channel whose `term_en_i` bit is 0 has no effect on that channel.
- R11: A done together with `cyc_err_i` ends the owning channel's transfer and raises its interrupt and error flag. The other channel is unaffected.
- R12: An interrupt stays high until the channel's `irq_clr_i` pulse, which also clears the error flag. A new interrupt event in the same cycle as the clear wins.
- R13: `cyc_done_i` while no cycle is outstanding is ignored and does not reduce any channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 2 | Per-channel start strobe |
| len_i | input | CNT_W | Cycle count loaded on start |
| term_en_i | input | 2 | Per-channel enable for the external terminate input |
| prio_i | input | 2 | Per-channel priority bit, 1 = high |
| req_i | input | 2 | Per-channel peripheral request level |
| term_i | input | 2 | Per-channel external terminate input |
| irq_clr_i | input | 2 | Per-channel interrupt clear strobe |
| cyc_done_i | input | 1 | Outstanding cycle has finished |
| cyc_err_i | input | 1 | Outstanding cycle finished with an error (valid with done) |
| cyc_req_o | output | 1 | A cycle is outstanding |
| cyc_ch_o | output | 1 | Owner of the outstanding cycle |
| active_o | output | 2 | Channel has a transfer in progress |
| irq_o | output | 2 | Per-channel interrupt to the host |
| err_o | output | 2 | Per-channel error flag, valid with the interrupt |

## Verification
A wrong turn pointer shows on `cyc_ch_o` at the next contested grant, within two cycles of the fault. A stale count shows as an interrupt that comes one done early or one done late. A terminate detector that acts on the level instead of the edge shows up only when a channel is restarted while the terminate input is still high. The scenarios are built to reach each of these states, and the ports are checked in the cycle right after the edge that should change them.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   localparam int NUM_CH = 2;

   typedef enum logic {
      CH_A = 1'b0,
      CH_B = 1'b1
   } ch_id_t;
endpackage

// File: rtl/dpa_chan.sv
module dpa_chan #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             term_en_i,
   input  logic             term_i,
   input  logic             req_i,
   input  logic             clr_i,
   input  logic             done_i,
   input  logic             err_i,
   output logic             elig_o,
   output logic             active_o,
   output logic             irq_o,
   output logic             err_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             active_q, irq_q, err_q, term_q;
   logic [CNT_W-1:0] cnt_q;
   logic             term_hit, last_done, err_end, start_ok, end_evt;

   assign term_hit  = term_i & ~term_q & term_en_i & active_q;
   assign err_end   = done_i & err_i & active_q;
   assign last_done = done_i & ~err_i & active_q & (cnt_q == ONE);
   assign end_evt   = term_hit | err_end | last_done;
   assign start_ok  = start_i & ~active_q & (len_i != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         irq_q    <= 1'b0;
         err_q    <= 1'b0;
         term_q   <= 1'b0;
         cnt_q    <= '0;
      end else begin
         term_q <= term_i;
         if (end_evt) begin
            active_q <= 1'b0;
         end else if (start_ok) begin
            active_q <= 1'b1;
         end
         if (start_ok) begin
            cnt_q <= len_i;
         end else if (done_i && active_q) begin
            cnt_q <= cnt_q - ONE;
         end
         if (end_evt) begin
            irq_q <= 1'b1;
         end else if (clr_i) begin
            irq_q <= 1'b0;
         end
         if (err_end && !term_hit) begin
            err_q <= 1'b1;
         end else if (clr_i && !end_evt) begin
            err_q <= 1'b0;
         end
      end
   end

   assign elig_o   = active_q & req_i;
   assign active_o = active_q;
   assign irq_o    = irq_q;
   assign err_o    = err_q;
endmodule

// File: rtl/dpa_pick.sv
module dpa_pick
   import dpa_pkg::*;
(
   input  logic [NUM_CH-1:0] elig_i,
   input  logic [NUM_CH-1:0] prio_i,
   input  ch_id_t            turn_i,
   output logic              valid_o,
   output ch_id_t            ch_o
);
   always_comb begin
      valid_o = |elig_i;
      ch_o    = turn_i;
      unique case (elig_i)
         2'b01:   ch_o = CH_A;
         2'b10:   ch_o = CH_B;
         2'b11: begin
            if (prio_i[0] != prio_i[1]) begin
               ch_o = prio_i[1] ? CH_B : CH_A;
            end else begin
               ch_o = turn_i;
            end
         end
         default: ch_o = turn_i;
      endcase
   end
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
   import dpa_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       start_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic [1:0]       term_en_i,
   input  logic [1:0]       prio_i,
   input  logic [1:0]       req_i,
   input  logic [1:0]       term_i,
   input  logic [1:0]       irq_clr_i,
   input  logic             cyc_done_i,
   input  logic             cyc_err_i,
   output logic             cyc_req_o,
   output logic             cyc_ch_o,
   output logic [1:0]       active_o,
   output logic [1:0]       irq_o,
   output logic [1:0]       err_o
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("dpa_arbiter: CNT_W must lie in 1..32");
   end
   if (NUM_CH != 2) begin : g_bad_num_ch
      $error("dpa_arbiter: exactly two channels are supported");
   end

   logic [NUM_CH-1:0] elig;
   logic              busy_q;
   ch_id_t            own_q, turn_q, pick_ch;
   logic              pick_valid, grant, finish;

   assign grant  = ~busy_q & pick_valid;
   assign finish = busy_q & cyc_done_i;

   dpa_pick pick_i (
      .elig_i  (elig),
      .prio_i  (prio_i),
      .turn_i  (turn_q),
      .valid_o (pick_valid),
      .ch_o    (pick_ch)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic chan_done;
      assign chan_done = finish & (own_q == ch_id_t'(c));

      dpa_chan #(.CNT_W(CNT_W)) chan_i (
         .clk       (clk),
         .rst       (rst),
         .start_i   (start_i[c]),
         .len_i     (len_i),
         .term_en_i (term_en_i[c]),
         .term_i    (term_i[c]),
         .req_i     (req_i[c]),
         .clr_i     (irq_clr_i[c]),
         .done_i    (chan_done),
         .err_i     (cyc_err_i),
         .elig_o    (elig[c]),
         .active_o  (active_o[c]),
         .irq_o     (irq_o[c]),
         .err_o     (err_o[c])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         own_q  <= CH_A;
         turn_q <= CH_A;
      end else if (grant) begin
         busy_q <= 1'b1;
         own_q  <= pick_ch;
         turn_q <= (pick_ch == CH_A) ? CH_B : CH_A;
      end else if (finish) begin
         busy_q <= 1'b0;
      end
   end

   assign cyc_req_o = busy_q;
   assign cyc_ch_o  = own_q;
endmodule

// File: rtl/dpa_arbiter_chk.sv
module dpa_arbiter_chk (
   input logic       clk,
   input logic       rst,
   input logic [1:0] prio_i,
   input logic [1:0] req_i,
   input logic [1:0] irq_clr_i,
   input logic       cyc_done_i,
   input logic       cyc_req_o,
   input logic       cyc_ch_o,
   input logic [1:0] active_o,
   input logic [1:0] irq_o
);
   assert_hold_cycle_R3: assert property (@(posedge clk) disable iff (rst)
      (cyc_req_o && !cyc_done_i) |=> (cyc_req_o && $stable(cyc_ch_o)));

   assert_gap_after_done_R3: assert property (@(posedge clk) disable iff (rst)
      (cyc_req_o && cyc_done_i) |=> !cyc_req_o);

   assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(cyc_req_o) |-> (($past(req_i) & (2'b01 << cyc_ch_o)) != 2'b00));

   assert_grant_needs_active_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(cyc_req_o) |-> (($past(active_o) & (2'b01 << cyc_ch_o)) != 2'b00));

   assert_prio_a_wins_R5: assert property (@(posedge clk) disable iff (rst)
      ($rose(cyc_req_o) && $past(active_o == 2'b11 && req_i == 2'b11 && prio_i == 2'b01))
      |-> (cyc_ch_o == 1'b0));

   assert_prio_b_wins_R5: assert property (@(posedge clk) disable iff (rst)
      ($rose(cyc_req_o) && $past(active_o == 2'b11 && req_i == 2'b11 && prio_i == 2'b10))
      |-> (cyc_ch_o == 1'b1));

   for (genvar c = 0; c < 2; c++) begin : g_ch
      assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (rst)
         (irq_o[c] && !irq_clr_i[c]) |=> irq_o[c]);

      assert_end_reports_R8: assert property (@(posedge clk) disable iff (rst)
         $fell(active_o[c]) |-> irq_o[c]);
   end
endmodule

bind dpa_arbiter dpa_arbiter_chk chk_i (
   .clk        (clk),
   .rst        (rst),
   .prio_i     (prio_i),
   .req_i      (req_i),
   .irq_clr_i  (irq_clr_i),
   .cyc_done_i (cyc_done_i),
   .cyc_req_o  (cyc_req_o),
   .cyc_ch_o   (cyc_ch_o),
   .active_o   (active_o),
   .irq_o      (irq_o)
);

// File: tb/dpa_arbiter_tb_top.sv
`timescale 1ns/1ps
module dpa_arbiter_tb_top;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst;
   logic [1:0]       start_i, term_en_i, prio_i, req_i, term_i, irq_clr_i;
   logic [CNT_W-1:0] len_i;
   logic             cyc_done_i, cyc_err_i;
   logic             cyc_req_o, cyc_ch_o;
   logic [1:0]       active_o, irq_o, err_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dpa_arbiter #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
      .term_en_i(term_en_i), .prio_i(prio_i), .req_i(req_i), .term_i(term_i),
      .irq_clr_i(irq_clr_i), .cyc_done_i(cyc_done_i), .cyc_err_i(cyc_err_i),
      .cyc_req_o(cyc_req_o), .cyc_ch_o(cyc_ch_o), .active_o(active_o),
      .irq_o(irq_o), .err_o(err_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; start_i = '0; term_en_i = '0; prio_i = '0; req_i = '0;
      term_i = '0; irq_clr_i = '0; len_i = '0; cyc_done_i = 1'b0; cyc_err_i = 1'b0;
      step(); step();
      rst = 1'b0;
   endtask

   task automatic start(input logic [1:0] which, input int len);
      start_i = which; len_i = CNT_W'(len);
      step();
      start_i = '0;
   endtask

   // waits for a cycle, checks its owner, completes it, checks the idle gap
   task automatic do_cycle(input int exp_ch, input bit with_err, input string req);
      int n = 0;
      while (!cyc_req_o && n < 8) begin
         step();
         n++;
      end
      chk(cyc_req_o == 1'b1, req, int'(cyc_req_o), 1);
      chk(int'(cyc_ch_o) == exp_ch, req, int'(cyc_ch_o), exp_ch);
      cyc_done_i = 1'b1; cyc_err_i = with_err;
      step();
      cyc_done_i = 1'b0; cyc_err_i = 1'b0;
      chk(cyc_req_o == 1'b0, "R3", int'(cyc_req_o), 0);
   endtask

   task automatic t_reset();
      do_reset();
      chk(cyc_req_o == 1'b0 && active_o == 2'b00, "R1", int'({cyc_req_o, active_o}), 0);
      chk(irq_o == 2'b00 && err_o == 2'b00, "R1", int'({irq_o, err_o}), 0);
   endtask

   task automatic t_start_rules();
      do_reset();
      start(2'b01, 0);
      chk(active_o == 2'b00, "R2", int'(active_o), 0);
      start(2'b01, 2);
      chk(active_o == 2'b01, "R2", int'(active_o), 1);
      start(2'b01, 5);              // ignored while active: still two cycles
      req_i = 2'b01;
      do_cycle(0, 1'b0, "R2");
      chk(active_o[0] == 1'b1 && irq_o[0] == 1'b0, "R2", int'({active_o[0], irq_o[0]}), 2);
      do_cycle(0, 1'b0, "R2");
      chk(active_o[0] == 1'b0 && irq_o[0] == 1'b1, "R2", int'({active_o[0], irq_o[0]}), 1);
   endtask

   task automatic t_req_level();
      do_reset();
      start(2'b01, 4);
      repeat (4) step();
      chk(cyc_req_o == 1'b0, "R4", int'(cyc_req_o), 0);
      req_i = 2'b01;
      do_cycle(0, 1'b0, "R4");
   endtask

   task automatic t_priority();
      do_reset();
      start(2'b11, 100);
      req_i = 2'b11; prio_i = 2'b10;
      repeat (3) do_cycle(1, 1'b0, "R5");
      prio_i = 2'b01;
      repeat (3) do_cycle(0, 1'b0, "R5");
   endtask

   task automatic t_interleave();
      do_reset();
      start(2'b11, 100);
      req_i = 2'b11;
      do_cycle(0, 1'b0, "R6");
      do_cycle(1, 1'b0, "R6");
      do_cycle(0, 1'b0, "R6");
      do_cycle(1, 1'b0, "R6");
   endtask

   task automatic t_turn_kept();
      do_reset();
      start(2'b11, 100);
      req_i = 2'b01;
      do_cycle(0, 1'b0, "R7");
      do_cycle(0, 1'b0, "R7");
      req_i = 2'b11;
      do_cycle(1, 1'b0, "R7");
      do_cycle(0, 1'b0, "R7");
   endtask

   task automatic t_complete();
      do_reset();
      start(2'b10, 3);
      req_i = 2'b10;
      do_cycle(1, 1'b0, "R8");
      do_cycle(1, 1'b0, "R8");
      chk(irq_o[1] == 1'b0, "R8", int'(irq_o[1]), 0);
      do_cycle(1, 1'b0, "R8");
      chk(active_o[1] == 1'b0 && irq_o[1] == 1'b1, "R8", int'({active_o[1], irq_o[1]}), 1);
      chk(err_o[1] == 1'b0, "R8", int'(err_o[1]), 0);
   endtask

   task automatic t_ext_term();
      do_reset();
      term_en_i = 2'b10;
      start(2'b10, 50);
      term_i = 2'b10;
      step();
      chk(active_o[1] == 1'b0 && irq_o[1] == 1'b1, "R9", int'({active_o[1], irq_o[1]}), 1);
      irq_clr_i = 2'b10; step(); irq_clr_i = '0;
      start(2'b10, 50);             // terminate still held high
      repeat (3) step();
      chk(active_o[1] == 1'b1 && irq_o[1] == 1'b0, "R9", int'({active_o[1], irq_o[1]}), 2);
      term_i = '0;
   endtask

   task automatic t_term_disabled();
      do_reset();
      term_en_i = 2'b10;
      start(2'b01, 50);
      term_i = 2'b01;
      repeat (3) step();
      chk(active_o[0] == 1'b1 && irq_o[0] == 1'b0, "R10", int'({active_o[0], irq_o[0]}), 2);
      term_i = '0;
   endtask

   task automatic t_cycle_error();
      do_reset();
      start(2'b11, 10);
      req_i = 2'b01;
      do_cycle(0, 1'b1, "R11");
      chk(active_o == 2'b10, "R11", int'(active_o), 2);
      chk(irq_o == 2'b01 && err_o == 2'b01, "R11", int'({irq_o, err_o}), 5);
   endtask

   task automatic t_irq_clear();
      do_reset();
      term_en_i = 2'b11;
      start(2'b11, 20);
      term_i = 2'b01; step(); term_i = '0;
      repeat (4) step();
      chk(irq_o[0] == 1'b1, "R12", int'(irq_o[0]), 1);
      irq_clr_i = 2'b11; term_i = 2'b10;   // clear on ch1 meets a new event
      step();
      irq_clr_i = '0; term_i = '0;
      chk(irq_o == 2'b10, "R12", int'(irq_o), 2);
   endtask

   task automatic t_stray_done();
      do_reset();
      cyc_done_i = 1'b1; step(); cyc_done_i = 1'b0;
      chk(cyc_req_o == 1'b0, "R13", int'(cyc_req_o), 0);
      start(2'b01, 2);
      cyc_done_i = 1'b1; step(); cyc_done_i = 1'b0;   // before any grant
      req_i = 2'b01;
      do_cycle(0, 1'b0, "R13");
      chk(active_o[0] == 1'b1, "R13", int'(active_o[0]), 1);
      do_cycle(0, 1'b0, "R13");
      chk(active_o[0] == 1'b0 && irq_o[0] == 1'b1, "R13", int'({active_o[0], irq_o[0]}), 1);
   endtask

   initial begin
      t_reset();
      t_start_rules();
      t_req_level();
      t_priority();
      t_interleave();
      t_turn_kept();
      t_complete();
      t_ext_term();
      t_term_disabled();
      t_cycle_error();
      t_irq_clear();
      t_stray_done();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule